// File: doc/BRIEF.md
# Privileged Trap-Return and System-Instruction Unit

This unit carries out a small core's privileged system instructions: the machine-level trap return, the supervisor-level trap return, wait-for-interrupt, and the address-translation fence. It holds the hart's current privilege level and the interrupt-enable, previous-enable and previous-privilege fields of the status register. The trap-virtual-memory, timeout-wait and trap-supervisor-return control bits come in from the CSR file as level inputs.

The decode stage raises one bit of a one-hot instruction strobe and presents both saved exception PCs. One clock later the unit raises exactly one result strobe. The result is a legal return with its target PC, an illegal-instruction trap, a misaligned-target trap, a halt request, or a flush request. A trap changes no state. A legal return updates the privilege level and the status fields together on the same clock edge. The CSR file can load the status fields through a write port when no instruction is in flight.

Top module: `priv_return_unit`

## Requirements
- R1: After a synchronous reset, `priv_o` reads 3 (machine), `stat_o` reads 0, and every result strobe is low.
- R2: Machine return (`instr_i` bit 0) succeeds only at machine privilege. At any lower level it raises `ill_o` with `cause_o` = 2.
- R3: Supervisor return (`instr_i` bit 1) raises `ill_o` (cause 2) at user privilege. It also does so at supervisor privilege while `tsr_i` is 1. At machine privilege it succeeds whatever the value of `tsr_i`.
- R4: With `HAS_COMPRESSED` = 0, a return whose target has a nonzero value in bits [1:0] raises `misalign_o` with `cause_o` = 0 and does not return. The privilege-level check takes priority over this check. This check takes priority over the `tsr_i` check.
- R5: A legal machine return sets the privilege to the old MPP, copies MPIE into MIE, sets MPIE to 1 and sets MPP to 0 (user).
- R6: A legal supervisor return sets the privilege to the old SPP (0 gives user, 1 gives supervisor), copies SPIE into SIE, sets SPIE to 1 and clears SPP.
- R7: An illegal or misaligned result leaves `priv_o` and `stat_o` unchanged.
- R8: Wait-for-interrupt (`instr_i` bit 2) raises `ill_o` (cause 2) at supervisor privilege while `tw_i` is 1. In every other case it raises `halt_o`.
- R9: The fence (`instr_i` bit 3) raises `ill_o` (cause 2) at user privilege, and at supervisor privilege while `tvm_i` is 1. In every other case it raises a one-cycle `flush_o`.
- R10: Each one-hot `instr_i` produces exactly one of `ret_o`, `ill_o`, `misalign_o`, `halt_o`, `flush_o`, one cycle later and for one cycle only. A zero or multi-bit `instr_i` produces no strobe and no state change.
- R11: `ret_pc_o` carries `mepc_i` (machine return) or `sepc_i` (supervisor return), as sampled with the strobe, in the same cycle as `ret_o`.
- R12: When `stat_we_i` is 1 and `instr_i` is zero, `stat_wdata_i` loads the status fields. The layout, shared by `stat_o`, is: [0] SIE, [1] MIE, [2] SPIE, [3] MPIE, [4] SPP, [6:5] MPP, [7] reads 0. An MPP write of 2 is stored as 0. A write is ignored while any `instr_i` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 4 | Instruction strobe: bit0 machine return, bit1 supervisor return, bit2 wait-for-interrupt, bit3 fence |
| mepc_i | input | XLEN | Saved machine exception PC |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| tsr_i | input | 1 | Trap supervisor return control bit |
| tw_i | input | 1 | Timeout-wait control bit |
| tvm_i | input | 1 | Trap virtual-memory control bit |
| stat_we_i | input | 1 | Status field write enable |
| stat_wdata_i | input | 8 | Status field write data |
| priv_o | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| stat_o | output | 8 | Status fields |
| ret_o | output | 1 | Legal return strobe |
| ret_pc_o | output | XLEN | Return target PC |
| ill_o | output | 1 | Illegal-instruction trap strobe |
| misalign_o | output | 1 | Misaligned-target trap strobe |
| halt_o | output | 1 | Halt request strobe |
| flush_o | output | 1 | Translation flush request strobe |
| cause_o | output | 4 | Exception code for a trap strobe |

## Verification
Some properties are checked on every cycle. A one-hot strobe is always followed by exactly one result. A trap never moves the privilege or the status fields. Each legal return rewrites the fields as R5 and R6 require, relative to the previous cycle. A returned target is always aligned, and a machine return only ever succeeds from machine level. Other behaviour only shows in the bench's directed scenarios: the priority order between the privilege, alignment and trap-supervisor-return checks, the wait-for-interrupt and fence outcomes for each privilege and control bit, the legalisation of a reserved MPP write, and a status write dropped while an instruction is in flight.

// File: rtl/priv_return_pkg.sv
package priv_return_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    // Status fields: bit 7 down to bit 0
    typedef struct packed {
        logic       rsv;
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       mie;
        logic       sie;
    } status_t;

    typedef enum logic [2:0] {
        RES_NONE  = 3'd0,
        RES_RET   = 3'd1,
        RES_ILL   = 3'd2,
        RES_MIS   = 3'd3,
        RES_HALT  = 3'd4,
        RES_FLUSH = 3'd5
    } result_e;

    localparam int NUM_OPS  = 4;
    localparam int OP_MRET  = 0;
    localparam int OP_SRET  = 1;
    localparam int OP_WFI   = 2;
    localparam int OP_FENCE = 3;

    localparam logic [3:0] CAUSE_MISALIGN = 4'd0;
    localparam logic [3:0] CAUSE_ILLEGAL  = 4'd2;

    // Reserved privilege encoding in MPP is stored as user
    function automatic logic [1:0] legal_mpp(input logic [1:0] v);
        return (v == PRIV_R) ? PRIV_U : v;
    endfunction

    function automatic logic below_super(input priv_e p);
        return (p == PRIV_U);
    endfunction

endpackage

// File: rtl/priv_ret_check.sv
module priv_ret_check
    import priv_return_pkg::*;
(
    input  logic [NUM_OPS-1:0] instr_i,
    input  priv_e              priv_i,
    input  logic               tgt_mis_i,
    input  logic               tsr_i,
    input  logic               tw_i,
    input  logic               tvm_i,
    output result_e            res_o
);

    logic is_one;
    assign is_one = $onehot(instr_i);

    always_comb begin
        res_o = RES_NONE;
        if (is_one) begin
            unique case (1'b1)
                instr_i[OP_MRET]: begin
                    if (priv_i != PRIV_M)   res_o = RES_ILL;
                    else if (tgt_mis_i)     res_o = RES_MIS;
                    else                    res_o = RES_RET;
                end
                instr_i[OP_SRET]: begin
                    if (below_super(priv_i))               res_o = RES_ILL;
                    else if (tgt_mis_i)                    res_o = RES_MIS;
                    else if (priv_i == PRIV_S && tsr_i)    res_o = RES_ILL;
                    else                                   res_o = RES_RET;
                end
                instr_i[OP_WFI]: begin
                    if (priv_i == PRIV_S && tw_i) res_o = RES_ILL;
                    else                          res_o = RES_HALT;
                end
                instr_i[OP_FENCE]: begin
                    if (below_super(priv_i) || (priv_i == PRIV_S && tvm_i))
                        res_o = RES_ILL;
                    else
                        res_o = RES_FLUSH;
                end
                default: res_o = RES_NONE;
            endcase
        end
    end

    // R10: a one-hot strobe always yields a result, anything else none
    always_comb begin
        a_r10_decode_total: assert (is_one == (res_o != RES_NONE));
    end

endmodule

// File: rtl/priv_ret_status.sv
module priv_ret_status
    import priv_return_pkg::*;
(
    input  logic [NUM_OPS-1:0] instr_i,
    input  result_e            res_i,
    input  priv_e              priv_i,
    input  status_t            stat_i,
    input  logic               we_i,
    input  logic [7:0]         wdata_i,
    output priv_e              priv_o,
    output status_t            stat_o
);

    status_t wr;

    always_comb begin
        wr      = status_t'(wdata_i);
        wr.rsv  = 1'b0;
        wr.mpp  = legal_mpp(wr.mpp);
    end

    always_comb begin
        priv_o = priv_i;
        stat_o = stat_i;
        if (res_i == RES_RET && instr_i[OP_MRET]) begin
            priv_o      = priv_e'(stat_i.mpp);
            stat_o.mie  = stat_i.mpie;
            stat_o.mpie = 1'b1;
            stat_o.mpp  = PRIV_U;
        end else if (res_i == RES_RET && instr_i[OP_SRET]) begin
            priv_o      = stat_i.spp ? PRIV_S : PRIV_U;
            stat_o.sie  = stat_i.spie;
            stat_o.spie = 1'b1;
            stat_o.spp  = 1'b0;
        end else if (we_i && instr_i == '0) begin
            stat_o = wr;
        end
    end

    // R12: the stored MPP never takes the reserved value
    always_comb begin
        a_r12_mpp_legal: assert (stat_o.mpp != PRIV_R || stat_i.mpp == PRIV_R);
    end

endmodule

// File: rtl/priv_return_unit.sv
module priv_return_unit
    import priv_return_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      instr_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic            tsr_i,
    input  logic            tw_i,
    input  logic            tvm_i,
    input  logic            stat_we_i,
    input  logic [7:0]      stat_wdata_i,
    output logic [1:0]      priv_o,
    output logic [7:0]      stat_o,
    output logic            ret_o,
    output logic [XLEN-1:0] ret_pc_o,
    output logic            ill_o,
    output logic            misalign_o,
    output logic            halt_o,
    output logic            flush_o,
    output logic [3:0]      cause_o
);

    localparam int ALIGN_BITS = 2;

    priv_e           priv_q, priv_nx;
    status_t         stat_q, stat_nx;
    result_e         res_d, res_q;
    logic [XLEN-1:0] tgt, pc_q;
    logic [NUM_OPS-1:0] op_q;
    logic            pend_q;
    logic            tgt_mis;

    assign tgt = instr_i[OP_SRET] ? sepc_i : mepc_i;

    generate
        if (HAS_COMPRESSED) begin : g_no_align
            assign tgt_mis = 1'b0;
        end else begin : g_align
            assign tgt_mis = |tgt[ALIGN_BITS-1:0];
        end
    endgenerate

    priv_ret_check u_check (
        .instr_i  (instr_i),
        .priv_i   (priv_q),
        .tgt_mis_i(tgt_mis),
        .tsr_i    (tsr_i),
        .tw_i     (tw_i),
        .tvm_i    (tvm_i),
        .res_o    (res_d)
    );

    priv_ret_status u_status (
        .instr_i(instr_i),
        .res_i  (res_d),
        .priv_i (priv_q),
        .stat_i (stat_q),
        .we_i   (stat_we_i),
        .wdata_i(stat_wdata_i),
        .priv_o (priv_nx),
        .stat_o (stat_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= PRIV_M;
            stat_q <= '0;
            res_q  <= RES_NONE;
            pc_q   <= '0;
            op_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            priv_q <= priv_nx;
            stat_q <= stat_nx;
            res_q  <= res_d;
            pc_q   <= tgt;
            op_q   <= instr_i;
            pend_q <= $onehot(instr_i);
        end
    end

    assign priv_o     = priv_q;
    assign stat_o     = stat_q;
    assign ret_pc_o   = pc_q;
    assign ret_o      = (res_q == RES_RET);
    assign ill_o      = (res_q == RES_ILL);
    assign misalign_o = (res_q == RES_MIS);
    assign halt_o     = (res_q == RES_HALT);
    assign flush_o    = (res_q == RES_FLUSH);
    assign cause_o    = ill_o ? CAUSE_ILLEGAL : CAUSE_MISALIGN;

    // R10: exactly one result strobe per accepted instruction
    a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
        pend_q == $onehot({ret_o, ill_o, misalign_o, halt_o, flush_o}));

    // R2: machine return succeeds only from machine level
    a_r2_mret_priv: assert property (@(posedge clk) disable iff (rst)
        (ret_o && op_q[OP_MRET]) |-> ($past(priv_q) == PRIV_M));

    // R3: supervisor return never succeeds from user, nor from S with TSR
    a_r3_sret_priv: assert property (@(posedge clk) disable iff (rst)
        (ret_o && op_q[OP_SRET]) |->
            ($past(priv_q) != PRIV_U && !($past(priv_q) == PRIV_S && $past(tsr_i))));

    // R5: machine return field update
    a_r5_mret_update: assert property (@(posedge clk) disable iff (rst)
        (ret_o && op_q[OP_MRET]) |->
            (stat_q.mie == $past(stat_q.mpie) && stat_q.mpie && stat_q.mpp == PRIV_U
             && priv_q == priv_e'($past(stat_q.mpp))));

    // R6: supervisor return field update
    a_r6_sret_update: assert property (@(posedge clk) disable iff (rst)
        (ret_o && op_q[OP_SRET]) |->
            (stat_q.sie == $past(stat_q.spie) && stat_q.spie && !stat_q.spp
             && priv_q == ($past(stat_q.spp) ? PRIV_S : PRIV_U)));

    // R7: a trap changes no state
    a_r7_trap_hold: assert property (@(posedge clk) disable iff (rst)
        (ill_o || misalign_o) |->
            (priv_q == $past(priv_q) && stat_q == $past(stat_q)));

    // R12: the reserved status bit reads zero
    a_r12_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        !stat_o[7]);

    generate
        if (!HAS_COMPRESSED) begin : g_align_chk
            // R4: returns land on aligned targets, misaligned results carry an unaligned one
            a_r4_ret_aligned: assert property (@(posedge clk) disable iff (rst)
                ret_o |-> (ret_pc_o[ALIGN_BITS-1:0] == '0));
            a_r4_mis_unaligned: assert property (@(posedge clk) disable iff (rst)
                misalign_o |-> (ret_pc_o[ALIGN_BITS-1:0] != '0));
        end
    endgenerate

endmodule

// File: tb/priv_return_unit_bench.sv
module priv_return_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  instr_i = '0;
    logic [31:0] mepc_i = '0, sepc_i = '0;
    logic        tsr_i = 1'b0, tw_i = 1'b0, tvm_i = 1'b0;
    logic        stat_we_i = 1'b0;
    logic [7:0]  stat_wdata_i = '0;
    logic [1:0]  priv_o;
    logic [7:0]  stat_o;
    logic        ret_o, ill_o, misalign_o, halt_o, flush_o;
    logic [31:0] ret_pc_o;
    logic [3:0]  cause_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [3:0] MRET = 4'b0001, SRET = 4'b0010, WFI = 4'b0100, FENCE = 4'b1000;

    always #2 clk = ~clk;

    priv_return_unit u_priv_return_unit (
        .clk(clk), .rst(rst), .instr_i(instr_i), .mepc_i(mepc_i), .sepc_i(sepc_i),
        .tsr_i(tsr_i), .tw_i(tw_i), .tvm_i(tvm_i), .stat_we_i(stat_we_i),
        .stat_wdata_i(stat_wdata_i), .priv_o(priv_o), .stat_o(stat_o), .ret_o(ret_o),
        .ret_pc_o(ret_pc_o), .ill_o(ill_o), .misalign_o(misalign_o), .halt_o(halt_o),
        .flush_o(flush_o), .cause_o(cause_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // strobes packed as {ret, ill, mis, halt, flush}
    task automatic chk_res(input string tag, input logic [4:0] exp, input logic [3:0] cause);
        chk({tag, " strobes"}, {ret_o, ill_o, misalign_o, halt_o, flush_o}, exp);
        if (exp[3] || exp[2]) chk({tag, " cause"}, cause_o, cause);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; instr_i = '0; stat_we_i = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic issue(input logic [3:0] ins, input logic [31:0] me, input logic [31:0] se);
        @(negedge clk); instr_i = ins; mepc_i = me; sepc_i = se;
        @(negedge clk); instr_i = '0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        @(negedge clk); stat_we_i = 1'b1; stat_wdata_i = v;
        @(negedge clk); stat_we_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 priv", priv_o, 2'd3);
        chk("R1 stat", stat_o, 8'h00);
        chk_res("R1", 5'b00000, 4'd0);
    endtask

    task automatic t_mret_from_machine();
        wr_stat(8'h28);                       // MPIE=1, MPP=1
        issue(MRET, 32'h100, 32'h0);
        chk_res("R5 mret", 5'b10000, 4'd0);
        chk("R11 mret pc", ret_pc_o, 32'h100);
        chk("R5 priv", priv_o, 2'd1);
        chk("R5 stat", stat_o, 8'h0A);
        @(negedge clk);
        chk_res("R10 single pulse", 5'b00000, 4'd0);
    endtask

    task automatic t_supervisor_path();
        issue(MRET, 32'h100, 32'h0);          // at S: illegal
        chk_res("R2 mret at S", 5'b01000, 4'd2);
        chk("R7 priv", priv_o, 2'd1);
        chk("R7 stat", stat_o, 8'h0A);
        wr_stat(8'h04);                       // SPIE=1, SPP=0
        issue(SRET, 32'h0, 32'h200);
        chk_res("R6 sret", 5'b10000, 4'd0);
        chk("R11 sret pc", ret_pc_o, 32'h200);
        chk("R6 priv", priv_o, 2'd0);
        chk("R6 stat", stat_o, 8'h05);
    endtask

    task automatic t_user_path();
        issue(SRET, 32'h0, 32'h200);
        chk_res("R3 sret at U", 5'b01000, 4'd2);
        issue(MRET, 32'h100, 32'h0);
        chk_res("R2 mret at U", 5'b01000, 4'd2);
        chk("R7 priv at U", priv_o, 2'd0);
        chk("R7 stat at U", stat_o, 8'h05);
        tw_i = 1'b1;
        issue(WFI, 32'h0, 32'h0);
        chk_res("R8 wfi at U", 5'b00010, 4'd0);
        tw_i = 1'b0;
        issue(FENCE, 32'h0, 32'h0);
        chk_res("R9 fence at U", 5'b01000, 4'd2);
    endtask

    task automatic t_machine_checks();
        do_reset();
        issue(MRET, 32'h102, 32'h0);
        chk_res("R4 mret misaligned", 5'b00100, 4'd0);
        chk("R4 priv held", priv_o, 2'd3);
        issue(SRET, 32'h0, 32'h201);
        chk_res("R4 sret misaligned", 5'b00100, 4'd0);
        issue(WFI, 32'h0, 32'h0);
        chk_res("R8 wfi at M", 5'b00010, 4'd0);
        tvm_i = 1'b1;
        issue(FENCE, 32'h0, 32'h0);
        chk_res("R9 fence at M", 5'b00001, 4'd0);
        tvm_i = 1'b0;
        wr_stat(8'h60);                       // MPP=3
        issue(MRET, 32'h40, 32'h0);
        chk_res("R5 mret to M", 5'b10000, 4'd0);
        chk("R5 priv stays M", priv_o, 2'd3);
        chk("R5 stat", stat_o, 8'h08);
        wr_stat(8'h10);                       // SPP=1
        tsr_i = 1'b1;
        issue(SRET, 32'h0, 32'h300);
        chk_res("R3 sret at M with tsr", 5'b10000, 4'd0);
        chk("R6 priv to S", priv_o, 2'd1);
        chk("R6 stat", stat_o, 8'h04);
    endtask

    task automatic t_supervisor_controls();
        issue(SRET, 32'h0, 32'h300);          // S, tsr still 1
        chk_res("R3 sret at S tsr", 5'b01000, 4'd2);
        issue(SRET, 32'h0, 32'h302);
        chk_res("R4 misalign over tsr", 5'b00100, 4'd0);
        tsr_i = 1'b0;
        issue(MRET, 32'h103, 32'h0);
        chk_res("R4 priv over misalign", 5'b01000, 4'd2);
        tw_i = 1'b1;
        issue(WFI, 32'h0, 32'h0);
        chk_res("R8 wfi at S tw", 5'b01000, 4'd2);
        tw_i = 1'b0;
        issue(WFI, 32'h0, 32'h0);
        chk_res("R8 wfi at S", 5'b00010, 4'd0);
        tvm_i = 1'b1;
        issue(FENCE, 32'h0, 32'h0);
        chk_res("R9 fence at S tvm", 5'b01000, 4'd2);
        tvm_i = 1'b0;
        issue(FENCE, 32'h0, 32'h0);
        chk_res("R9 fence at S", 5'b00001, 4'd0);
        @(negedge clk);
        chk("R9 flush one cycle", flush_o, 1'b0);
        chk("R7 priv after traps", priv_o, 2'd1);
        chk("R7 stat after traps", stat_o, 8'h04);
    endtask

    task automatic t_bad_strobe();
        issue(4'b0011, 32'h0, 32'h0);
        chk_res("R10 multi-hot", 5'b00000, 4'd0);
        chk("R10 priv held", priv_o, 2'd1);
        chk("R10 stat held", stat_o, 8'h04);
    endtask

    task automatic t_status_writes();
        wr_stat(8'hFF);
        chk("R12 full write", stat_o, 8'h7F);
        wr_stat(8'h40);
        chk("R12 mpp legalised", stat_o, 8'h00);
        @(negedge clk); instr_i = WFI; stat_we_i = 1'b1; stat_wdata_i = 8'h1F;
        @(negedge clk); instr_i = '0; stat_we_i = 1'b0;
        chk_res("R12 wfi with write", 5'b00010, 4'd0);
        chk("R12 write dropped", stat_o, 8'h00);
    endtask

    initial begin
        t_reset();
        t_mret_from_machine();
        t_supervisor_path();
        t_user_path();
        t_machine_checks();
        t_supervisor_controls();
        t_bad_strobe();
        t_status_writes();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule